// File: doc/BRIEF.md
# Single-Pass 128-bit Vector Permute Unit

This block rearranges the elements of two 128-bit operands, a destination and a source, into one 128-bit result. One crossbar spans the whole vector. Any byte of either operand can therefore land in any byte of the result, and an operation that moves data across the middle of the vector completes in a single pass. There is no staging through separate 64-bit halves.

Each cycle the caller presents an operation code, both operands, an 8-bit immediate and a valid flag. The result and a matching valid flag appear one clock edge later, and a new operation may be issued on every cycle. Six operations are provided:

- a two-source dword shuffle,
- a one-source dword shuffle,
- a low interleave,
- a high interleave,
- a byte-align concatenate-and-shift,
- a byte shuffle whose control bytes come from the source operand.

Top module: `vshuf_top`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and out_result is all zeros.
- R2: out_valid equals in_valid of the previous cycle, and out_result holds the result of the operation issued in the previous cycle (latency of exactly one cycle).
- R3: Operations issued on consecutive cycles each produce their own correct result on consecutive cycles, with no stall.
- R4: Op code 0 (two-source dword shuffle): result dword k takes dword imm[2k+1:2k] of the destination for k=0,1, and of the source for k=2,3. Bits [63:0] come only from the destination and bits [127:64] come only from the source. Any dword may cross the 64-bit boundary.
- R5: Op code 1 (one-source dword shuffle): result dword k is dword imm[2k+1:2k] of the source, for k=0..3.
- R6: Op code 2 (low interleave): the result dwords, from dword 0 upward, are dst0, src0, dst1, src1.
- R7: Op code 3 (high interleave): the result dwords, from dword 0 upward, are dst2, src2, dst3, src3.
- R8: Op code 4 (byte align): {dst, src} forms a 256-bit value that is shifted right by imm bytes, and the low 128 bits are kept. An imm of 32 or more yields zero.
- R9: Op code 5 (byte shuffle): for result byte k, the control byte is source byte k. If its bit 7 is set, result byte k is zero. Otherwise result byte k is the destination byte indexed by control bits [3:0].
- R10: Op codes 6 and 7 produce an all-zero result.
- R11: While in_valid is 0, out_result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 3 | Operation code |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand (control bytes for op 5) |
| in_imm | input | 8 | Immediate selector or byte shift count |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 128 | Registered result |

## Verification
The bench builds the unit with its default widths: a 128-bit vector, 32-bit dwords, bytes as elements and an 8-bit immediate. With these widths every dword and byte index is visible. Shuffle immediates can pull the top dword of the destination into dword 0, a cross-boundary move. The align count reaches the edges at 0, 16, 31 and 32 and beyond. Byte-shuffle controls mix set zero bits with stray upper index bits.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
  localparam int VEC_W    = 128;
  localparam int DW_W     = 32;
  localparam int BYTE_W   = 8;
  localparam int IMM_W    = 8;
  localparam int NUM_DW   = VEC_W / DW_W;
  localparam int NUM_BYTE = VEC_W / BYTE_W;
  localparam int SEL_W    = $clog2(NUM_DW);
  localparam int BIDX_W   = $clog2(NUM_BYTE);
  localparam int CAT_BYTES = 2 * NUM_BYTE;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [2:0] {
    OP_PS2 = 3'd0,
    OP_PS1 = 3'd1,
    OP_ILO = 3'd2,
    OP_IHI = 3'd3,
    OP_ALN = 3'd4,
    OP_BSH = 3'd5
  } vshuf_op_e;

  function automatic logic [DW_W-1:0] pick_dw(vec_t v, logic [SEL_W-1:0] s);
    return v[s*DW_W +: DW_W];
  endfunction

  // lower result dwords from lo_src, upper from hi_src, selected by imm fields
  function automatic vec_t dw_shuffle(vec_t lo_src, vec_t hi_src, logic [IMM_W-1:0] imm);
    vec_t r;
    for (int k = 0; k < NUM_DW; k++) begin
      logic [SEL_W-1:0] s;
      s = imm[k*SEL_W +: SEL_W];
      r[k*DW_W +: DW_W] = (k < NUM_DW/2) ? pick_dw(lo_src, s) : pick_dw(hi_src, s);
    end
    return r;
  endfunction

  function automatic vec_t interleave(vec_t d, vec_t s, logic upper);
    vec_t r;
    int base;
    base = upper ? NUM_DW/2 : 0;
    for (int k = 0; k < NUM_DW/2; k++) begin
      r[(2*k)*DW_W   +: DW_W] = d[(base+k)*DW_W +: DW_W];
      r[(2*k+1)*DW_W +: DW_W] = s[(base+k)*DW_W +: DW_W];
    end
    return r;
  endfunction

  function automatic vec_t byte_align(vec_t d, vec_t s, logic [IMM_W-1:0] imm);
    logic [2*VEC_W-1:0] cat;
    logic [2*VEC_W-1:0] sh;
    cat = {d, s};
    sh  = cat >> ({3'b000, imm} * BYTE_W);
    if (int'(imm) >= CAT_BYTES) sh = '0;
    return sh[VEC_W-1:0];
  endfunction

  function automatic vec_t byte_shuffle(vec_t d, vec_t ctl);
    vec_t r;
    for (int k = 0; k < NUM_BYTE; k++) begin
      logic [BYTE_W-1:0] c;
      c = ctl[k*BYTE_W +: BYTE_W];
      r[k*BYTE_W +: BYTE_W] = c[BYTE_W-1] ? '0 : d[c[BIDX_W-1:0]*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/vshuf_dw_xbar.sv
module vshuf_dw_xbar
  import vshuf_pkg::*;
(
  input  logic [2:0]       op,
  input  vec_t             dst,
  input  vec_t             src,
  input  logic [IMM_W-1:0] imm,
  output vec_t             dw_res
);
  vec_t two_src, one_src, il_lo, il_hi;

  assign two_src = dw_shuffle(dst, src, imm);
  assign one_src = dw_shuffle(src, src, imm);
  assign il_lo   = interleave(dst, src, 1'b0);
  assign il_hi   = interleave(dst, src, 1'b1);

  always_comb begin
    unique case (op[1:0])
      2'd0:    dw_res = two_src;
      2'd1:    dw_res = one_src;
      2'd2:    dw_res = il_lo;
      default: dw_res = il_hi;
    endcase
  end

  // R6
  always_comb begin
    if (op == OP_ILO)
      ilo_first_chk: assert (dw_res[DW_W-1:0] == dst[DW_W-1:0]);
  end
endmodule

// File: rtl/vshuf_byte_xbar.sv
module vshuf_byte_xbar
  import vshuf_pkg::*;
(
  input  logic             op_is_align,
  input  vec_t             dst,
  input  vec_t             src,
  input  logic [IMM_W-1:0] imm,
  output vec_t             byte_res
);
  vec_t aligned, bshuf;
  logic align_overrun;

  assign align_overrun = (int'(imm) >= CAT_BYTES);
  assign aligned  = byte_align(dst, src, imm);
  assign bshuf    = byte_shuffle(dst, src);
  assign byte_res = op_is_align ? aligned : bshuf;

  // R8
  always_comb begin
    if (align_overrun)
      align_wide_zero_chk: assert (aligned == '0);
  end

  // R9
  always_comb begin
    for (int k = 0; k < NUM_BYTE; k++) begin
      if (src[k*BYTE_W + BYTE_W-1])
        bshuf_zero_chk: assert (bshuf[k*BYTE_W +: BYTE_W] == '0);
    end
  end
endmodule

// File: rtl/vshuf_top.sv
module vshuf_top
  import vshuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         in_op,
  input  logic [VEC_W-1:0]   in_dst,
  input  logic [VEC_W-1:0]   in_src,
  input  logic [IMM_W-1:0]   in_imm,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_result
);
  vec_t dw_res, byte_res, nxt_res;
  logic op_dword, op_byte;

  assign op_dword = (in_op[2] == 1'b0);
  assign op_byte  = (in_op == OP_ALN) || (in_op == OP_BSH);

  vshuf_dw_xbar u_dw (
    .op(in_op), .dst(in_dst), .src(in_src), .imm(in_imm), .dw_res(dw_res)
  );

  vshuf_byte_xbar u_byte (
    .op_is_align(in_op == OP_ALN), .dst(in_dst), .src(in_src), .imm(in_imm),
    .byte_res(byte_res)
  );

  always_comb begin
    if (op_dword)     nxt_res = dw_res;
    else if (op_byte) nxt_res = byte_res;
    else              nxt_res = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= nxt_res;
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

  // R10
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[2] && in_op[1]) |=> (out_result == '0));

  // R4
  ps2_low_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_PS2 && in_imm[1:0] == 2'd3) |=>
    (out_result[DW_W-1:0] == $past(in_dst[VEC_W-1 -: DW_W])));
endmodule

// File: tb/test_vshuf_top.sv
`timescale 1ns/1ps
module test_vshuf_top;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic [2:0]   in_op;
  logic [127:0] in_dst, in_src;
  logic [7:0]   in_imm;
  logic         out_valid;
  logic [127:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vshuf_top i_vshuf_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [31:0] dwd(logic [127:0] v, int i);
    return v[i*32 +: 32];
  endfunction

  function automatic logic [127:0] ref_op(logic [2:0] op, logic [127:0] d,
                                          logic [127:0] s, logic [7:0] imm);
    logic [127:0] r = '0;
    logic [7:0] cat [32];
    case (op)
      3'd0: r = {dwd(s, imm[7:6]), dwd(s, imm[5:4]), dwd(d, imm[3:2]), dwd(d, imm[1:0])};
      3'd1: r = {dwd(s, imm[7:6]), dwd(s, imm[5:4]), dwd(s, imm[3:2]), dwd(s, imm[1:0])};
      3'd2: r = {dwd(s, 1), dwd(d, 1), dwd(s, 0), dwd(d, 0)};
      3'd3: r = {dwd(s, 3), dwd(d, 3), dwd(s, 2), dwd(d, 2)};
      3'd4: begin
        for (int i = 0; i < 16; i++) begin
          cat[i]    = s[i*8 +: 8];
          cat[i+16] = d[i*8 +: 8];
        end
        for (int k = 0; k < 16; k++)
          r[k*8 +: 8] = (int'(imm) + k < 32) ? cat[int'(imm) + k] : 8'h00;
      end
      3'd5: begin
        for (int k = 0; k < 16; k++) begin
          logic [7:0] c = s[k*8 +: 8];
          r[k*8 +: 8] = c[7] ? 8'h00 : d[int'(c[3:0])*8 +: 8];
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one op, wait one edge, check result and valid
  task automatic run_op(string req, logic [2:0] op, logic [127:0] d,
                        logic [127:0] s, logic [7:0] imm);
    in_valid = 1; in_op = op; in_dst = d; in_src = s; in_imm = imm;
    @(posedge clk); #1;
    check(req, out_result, ref_op(op, d, s, imm));
    check({req, " valid"}, {127'd0, out_valid}, 128'd1);
  endtask

  localparam logic [127:0] DA = 128'h33333333_22222222_11111111_00000000;
  localparam logic [127:0] SA = 128'h77777777_66666666_55555555_44444444;
  localparam logic [127:0] DB = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
  localparam logic [127:0] SB = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  task automatic t_reset();
    rst = 1; in_valid = 0; in_op = 0; in_dst = DB; in_src = SB; in_imm = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 result", out_result, '0);
    check("R1 valid", {127'd0, out_valid}, '0);
    rst = 0;
  endtask

  task automatic t_ps2();
    run_op("R4 imm1B", 3'd0, DA, SA, 8'h1B);
    run_op("R4 crosshalf", 3'd0, DB, SB, 8'h03);
    run_op("R4 E4", 3'd0, DB, SB, 8'hE4);
  endtask

  task automatic t_ps1();
    run_op("R5 reverse", 3'd1, DA, SB, 8'h1B);
    run_op("R5 bcast", 3'd1, DB, SA, 8'hFF);
  endtask

  task automatic t_ilv();
    run_op("R6 low", 3'd2, DA, SA, 8'h00);
    run_op("R7 high", 3'd3, DA, SA, 8'h00);
  endtask

  task automatic t_align();
    run_op("R8 imm0", 3'd4, DB, SB, 8'd0);
    run_op("R8 imm5", 3'd4, DB, SB, 8'd5);
    run_op("R8 imm16", 3'd4, DB, SB, 8'd16);
    run_op("R8 imm31", 3'd4, DB, SB, 8'd31);
    run_op("R8 imm32", 3'd4, DB, SB, 8'd32);
    run_op("R8 imm200", 3'd4, DB, SB, 8'd200);
  endtask

  task automatic t_bshuf();
    run_op("R9 reverse", 3'd5, DB, 128'h00010203_04050607_08090A0B_0C0D0E0F, 8'h00);
    run_op("R9 zeros", 3'd5, DB, 128'h80FF0F70_8C031225_9A7B3E01_FF00C060, 8'h00);
  endtask

  task automatic t_badop();
    run_op("R10 op6", 3'd6, DB, SB, 8'h55);
    run_op("R4 refill", 3'd0, DB, SB, 8'h55);
    run_op("R10 op7", 3'd7, DB, SB, 8'hAA);
  endtask

  task automatic t_hold();
    logic [127:0] kept;
    run_op("R11 setup", 3'd1, DB, SB, 8'h4E);
    kept = out_result;
    in_valid = 0; in_op = 3'd0; in_dst = SB; in_src = DB; in_imm = 8'h93;
    repeat (3) @(posedge clk);
    #1;
    check("R11 hold", out_result, kept);
    check("R2 idle valid", {127'd0, out_valid}, '0);
  endtask

  task automatic t_b2b();
    for (int i = 0; i < 8; i++) begin
      logic [127:0] d = DB ^ {4{32'(i * 32'h01010101)}};
      logic [127:0] s = SB + 128'(i);
      run_op("R3 b2b", 3'(i % 6), d, s, 8'(i * 37));
    end
  endtask

  initial begin
    t_reset();
    t_ps2();
    t_ps1();
    t_ilv();
    t_align();
    t_bshuf();
    t_badop();
    t_hold();
    t_b2b();
    in_valid = 0;
    @(posedge clk); #1;
    check("R2 drop", {127'd0, out_valid}, '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule